// File: doc/BRIEF.md
# Parity-Protected Word RAM with Page Write Lock

This block is an on-chip RAM wrapper. It stores 32-bit words, and each word carries four even-parity bits, one for each byte lane, so every entry in the array is 36 bits wide. Each bus write computes fresh parity for the byte lanes it updates. Each read recomputes the parity of the returned word and compares it with the stored bits. A mismatch is reported only while checking is switched on. It then raises a one-cycle non-maskable error pulse and sets a sticky flag. When the break link has been armed, the same pulse also appears on a break output. Software clears the flag.

The window begins at byte address 0x1000_0000 and is split into 1 KB pages. Each page has its own write-lock bit. A write to a locked page changes nothing in the array and produces a one-cycle violation pulse. A small register port controls the block: the parity-check switch, the page locks, the break-link arm bit, flag clearing, and a per-lane field that flips the parity stored by later writes. That last field is how an error path is provoked on purpose.

A single access state machine records what the previous bus cycle did, and the response outputs are decoded from that state. Its states are ST_IDLE (no request, or a write outside the window), ST_RD_RESP (a read inside the window is being answered), ST_RD_VOID (a read outside the window is answered with zero), ST_WR_DONE (a write was committed) and ST_WR_BLOCK (a write was refused by its page lock). Every clock edge moves to the state that matches the request sampled at that edge, whatever the current state is.

Top module: `ppsram_top`

## Requirements
- R1: After reset, bus_rvalid, bus_rdata, wr_viol, par_err, brk_out, err_flag, par_en_o, prot_o and link_o are all zero.
- R2: A read request (bus_req=1, bus_we=0) sampled at a clock edge is answered in the next cycle with bus_rvalid=1 and the stored word on bus_rdata. Reads may be issued back to back.
- R3: A write updates only the byte lanes whose bus_be bit is set (bit i covers data bits [8i+7:8i]). The other lanes keep their data and their parity.
- R4: The stored parity bit of lane i is the XOR of that lane's eight data bits, flipped when cfg inject bit i (cfg_sel=4, cfg_wdata[3:0]) is set. With injection off, reading the word back never reports an error.
- R5: When parity checking is on (cfg_sel=0, cfg_wdata[0]=1) and any lane of a read word has a mismatch, par_err is high for exactly the cycle in which bus_rvalid carries that word.
- R6: When parity checking is off, a read of a mismatching word raises neither par_err nor err_flag.
- R7: err_flag rises in the cycle after a par_err pulse and stays set until a write with cfg_sel=3 and cfg_wdata[0]=1. A new error in the same cycle as that clear leaves the flag set.
- R8: brk_out follows par_err while the break link is armed. The link is armed by cfg_sel=2 with cfg_wdata[0]=1, and no register write clears it once armed.
- R9: The page index is (bus_addr-0x1000_0000)>>10 and is locked by prot_o bit of that index (cfg_sel=1, cfg_wdata[NUM_PAGES-1:0]). A write to a locked page leaves the array unchanged and gives wr_viol=1 in the following cycle only.
- R10: An access outside the window [0x1000_0000, 0x1000_0000+NUM_PAGES*1024) changes no stored word and raises no wr_viol. A read there returns bus_rvalid=1 with bus_rdata=0 and no par_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address (word aligned) |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| wr_viol | output | 1 | Pulse: write refused by page lock |
| cfg_we | input | 1 | Register-port write strobe |
| cfg_sel | input | 3 | 0 check enable, 1 page locks, 2 link arm, 3 flag clear, 4 parity inject |
| cfg_wdata | input | 32 | Register-port write data |
| par_en_o | output | 1 | Parity check enabled |
| prot_o | output | NUM_PAGES | Page lock bits |
| link_o | output | 1 | Break link armed |
| err_flag | output | 1 | Sticky parity-error flag |
| par_err | output | 1 | Non-maskable parity error pulse |
| brk_out | output | 1 | Break output driven by the parity error |

## Verification
If the access state goes wrong, it shows up one cycle after the bad request: bus_rvalid or wr_viol is missing or extra, or read data appears for an access outside the window. Stored data or parity in the wrong state stays hidden until the word is read back, and is then exposed as the wrong bus_rdata or an unexpected par_err in that response cycle. A fault in the flag or link registers appears on err_flag or link_o in the cycle after the event that should have moved them. The bench therefore re-reads every location it touched after locked writes, partial writes and out-of-window writes.

// File: rtl/ppsram_pkg.sv
package ppsram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_RESP  = 3'd1,
        ST_RD_VOID  = 3'd2,
        ST_WR_DONE  = 3'd3,
        ST_WR_BLOCK = 3'd4
    } acc_state_e;

    typedef enum logic [2:0] {
        CFG_PAR_EN  = 3'd0,
        CFG_PROTECT = 3'd1,
        CFG_LINK    = 3'd2,
        CFG_CLEAR   = 3'd3,
        CFG_INJECT  = 3'd4
    } cfg_sel_e;

    localparam int LANES = 4;

    // even parity per byte lane
    function automatic logic [LANES-1:0] lane_parity(input logic [8*LANES-1:0] d);
        logic [LANES-1:0] p;
        for (int i = 0; i < LANES; i++) begin
            p[i] = ^d[8*i +: 8];
        end
        return p;
    endfunction

endpackage

// File: rtl/ppsram_lanes.sv
module ppsram_lanes #(
    parameter int DEPTH = 1024,
    parameter int LANES = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int WW    = 9 * LANES
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LANES-1:0] wr_be,
    input  logic [WW-1:0]    wr_word,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WW-1:0]    rd_word
);

    // word layout: data lanes in [8*LANES-1:0], parity bits above
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [8:0] store [DEPTH];
        logic [8:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[g]) begin
                store[wr_idx] <= {wr_word[8*LANES + g], wr_word[8*g +: 8]};
            end
            if (rd_en) begin
                lane_q <= store[rd_idx];
            end
        end

        assign rd_word[8*g +: 8]     = lane_q[7:0];
        assign rd_word[8*LANES + g]  = lane_q[8];
    end

endmodule

// File: rtl/ppsram_cfg.sv
module ppsram_cfg
    import ppsram_pkg::*;
#(
    parameter int NUM_PAGES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_sel,
    input  logic [31:0]          cfg_wdata,
    input  logic                 err_in,
    output logic                 par_en,
    output logic [NUM_PAGES-1:0] prot,
    output logic                 link,
    output logic [LANES-1:0]     inject,
    output logic                 flag
);

    logic clr_req;
    assign clr_req = cfg_we && (cfg_sel == CFG_CLEAR) && cfg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_en <= 1'b0;
            prot   <= '0;
            link   <= 1'b0;
            inject <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                CFG_PAR_EN:  par_en <= cfg_wdata[0];
                CFG_PROTECT: prot   <= cfg_wdata[NUM_PAGES-1:0];
                CFG_LINK:    link   <= link | cfg_wdata[0];
                CFG_INJECT:  inject <= cfg_wdata[LANES-1:0];
                default:     ;
            endcase
        end
    end

    // sticky flag: a new error outranks a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (err_in) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    a_r7_flag_follows_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_in |=> flag);

    a_r8_link_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        link |=> link);

endmodule

// File: rtl/ppsram_top.sv
module ppsram_top
    import ppsram_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'h1000_0000,
    parameter int          NUM_PAGES  = 4,
    parameter int          PAGE_BYTES = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [31:0]          bus_addr,
    input  logic [3:0]           bus_be,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    output logic                 wr_viol,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_sel,
    input  logic [31:0]          cfg_wdata,
    output logic                 par_en_o,
    output logic [NUM_PAGES-1:0] prot_o,
    output logic                 link_o,
    output logic                 err_flag,
    output logic                 par_err,
    output logic                 brk_out
);

    localparam int          WORDS_PER_PAGE = PAGE_BYTES / 4;
    localparam int          DEPTH          = NUM_PAGES * WORDS_PER_PAGE;
    localparam int          IDX_W          = $clog2(DEPTH);
    localparam int          PG_SH          = $clog2(PAGE_BYTES);
    localparam int          PG_W           = $clog2(NUM_PAGES);
    localparam logic [31:0] MEM_BYTES      = 32'(NUM_PAGES * PAGE_BYTES);
    localparam int          WW             = 9 * LANES;

    // address decode
    logic [31:0]      offset;
    logic             in_win;
    logic [IDX_W-1:0] widx;
    logic [PG_W-1:0]  page;
    logic             page_locked;

    assign offset      = bus_addr - BASE_ADDR;
    assign in_win      = (bus_addr >= BASE_ADDR) && (offset < MEM_BYTES);
    assign widx        = offset[IDX_W+1:2];
    assign page        = offset[PG_SH+PG_W-1:PG_SH];
    assign page_locked = prot_o[page];

    // configuration
    logic [LANES-1:0] inject;
    logic             link;

    ppsram_cfg #(.NUM_PAGES(NUM_PAGES)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .err_in    (par_err),
        .par_en    (par_en_o),
        .prot      (prot_o),
        .link      (link),
        .inject    (inject),
        .flag      (err_flag)
    );
    assign link_o = link;

    // access state machine
    acc_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case ({bus_req, bus_we})
            2'b10:   state_d = in_win ? ST_RD_RESP : ST_RD_VOID;
            2'b11:   state_d = !in_win    ? ST_IDLE
                             : page_locked ? ST_WR_BLOCK : ST_WR_DONE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // array
    logic          arr_we;
    logic          arr_re;
    logic [WW-1:0] wr_word;
    logic [WW-1:0] rd_word;

    assign arr_we  = (state_d == ST_WR_DONE);
    assign arr_re  = (state_d == ST_RD_RESP);
    assign wr_word = {lane_parity(bus_wdata) ^ inject, bus_wdata};

    ppsram_lanes #(.DEPTH(DEPTH), .LANES(LANES)) u_lanes (
        .clk     (clk),
        .wr_en   (arr_we),
        .wr_idx  (widx),
        .wr_be   (bus_be),
        .wr_word (wr_word),
        .rd_en   (arr_re),
        .rd_idx  (widx),
        .rd_word (rd_word)
    );

    // checker on the returned word
    logic mismatch;
    assign mismatch = (rd_word[WW-1:8*LANES] != lane_parity(rd_word[8*LANES-1:0]));

    // outputs decoded from the state
    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        wr_viol    = 1'b0;
        par_err    = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_RD_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rd_word[8*LANES-1:0];
                par_err    = par_en_o && mismatch;
            end
            ST_RD_VOID:  bus_rvalid = 1'b1;
            ST_WR_DONE:  ;
            ST_WR_BLOCK: wr_viol = 1'b1;
            default:     ;
        endcase
    end

    assign brk_out = par_err && link;

    a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    a_r9_locked_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && in_win && page_locked) |=> (wr_viol && !bus_rvalid));

    a_r5_err_only_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> bus_rvalid);

    a_r10_void_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !in_win) |=> (bus_rdata == 32'd0 && !par_err));

endmodule

// File: tb/sim_ppsram_top.sv
module sim_ppsram_top;

    localparam int          PERIOD = 10;
    localparam logic [31:0] BASE   = 32'h1000_0000;
    localparam int          NPG    = 4;
    localparam int          WIN    = NPG * 1024;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            bus_req = 0, bus_we = 0;
    logic [31:0]     bus_addr = 0;
    logic [3:0]      bus_be = 0;
    logic [31:0]     bus_wdata = 0;
    logic [31:0]     bus_rdata;
    logic            bus_rvalid, wr_viol;
    logic            cfg_we = 0;
    logic [2:0]      cfg_sel = 0;
    logic [31:0]     cfg_wdata = 0;
    logic            par_en_o, link_o, err_flag, par_err, brk_out;
    logic [NPG-1:0]  prot_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    ppsram_top #(.BASE_ADDR(BASE), .NUM_PAGES(NPG), .PAGE_BYTES(1024)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .wr_viol(wr_viol),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .par_en_o(par_en_o), .prot_o(prot_o), .link_o(link_o),
        .err_flag(err_flag), .par_err(par_err), .brk_out(brk_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit [31:0]     m_data [int];
    bit [3:0]      m_par  [int];
    bit            m_en, m_link, m_flag;
    bit [NPG-1:0]  m_prot;
    bit [3:0]      m_inj;
    bit            e_rvalid, e_viol, e_err, e_brk;
    bit [31:0]     e_rdata;

    always @(posedge clk or negedge rst_n) begin : model
        bit        old_err, raw, inwin, clr;
        bit [31:0] off;
        int        idx, pg;
        bit [3:0]  p;
        if (!rst_n) begin
            m_en = 0; m_link = 0; m_flag = 0; m_prot = 0; m_inj = 0;
            e_rvalid = 0; e_viol = 0; e_err = 0; e_brk = 0; e_rdata = 0;
        end else begin
            old_err = e_err;
            off   = bus_addr - BASE;
            inwin = (bus_addr >= BASE) && (off < WIN);
            idx   = int'(off >> 2);
            pg    = int'(off >> 10);
            e_rvalid = 0; e_viol = 0; e_rdata = 0; raw = 0;
            if (bus_req && bus_we && inwin) begin
                if (m_prot[pg]) e_viol = 1;
                else begin
                    if (!m_data.exists(idx)) begin m_data[idx] = 0; m_par[idx] = 0; end
                    for (int l = 0; l < 4; l++) if (bus_be[l]) begin
                        m_data[idx][8*l +: 8] = bus_wdata[8*l +: 8];
                        m_par[idx][l] = (^bus_wdata[8*l +: 8]) ^ m_inj[l];
                    end
                end
            end else if (bus_req && !bus_we) begin
                e_rvalid = 1;
                if (inwin && m_data.exists(idx)) begin
                    e_rdata = m_data[idx];
                    for (int l = 0; l < 4; l++) p[l] = ^m_data[idx][8*l +: 8];
                    raw = (p != m_par[idx]);
                end
            end
            clr = 0;
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: m_en = cfg_wdata[0];
                    3'd1: m_prot = cfg_wdata[NPG-1:0];
                    3'd2: m_link = m_link | cfg_wdata[0];
                    3'd3: clr = cfg_wdata[0];
                    3'd4: m_inj = cfg_wdata[3:0];
                    default: ;
                endcase
            end
            m_flag = old_err ? 1'b1 : (clr ? 1'b0 : m_flag);
            e_err  = raw && m_en;
            e_brk  = e_err && m_link;
        end
    end

    // compare every cycle, a quarter period after the edge
    always @(posedge clk) begin
        #(PERIOD/4);
        if (rst_n && !done) begin
            chk("R2 rvalid", 32'(bus_rvalid), 32'(e_rvalid));
            chk("R2/R3 rdata", bus_rdata, e_rdata);
            chk("R9 wr_viol", 32'(wr_viol), 32'(e_viol));
            chk("R5 par_err", 32'(par_err), 32'(e_err));
            chk("R7 err_flag", 32'(err_flag), 32'(m_flag));
            chk("R8 brk_out", 32'(brk_out), 32'(e_brk));
            chk("R8 link_o", 32'(link_o), 32'(m_link));
            chk("R9 prot_o", 32'(prot_o), 32'(m_prot));
            chk("R6 par_en_o", 32'(par_en_o), 32'(m_en));
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle_bus();
        bus_req = 0; bus_we = 0; cfg_we = 0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic cfg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    // read and check the response explicitly
    task automatic rd(input string tag, input logic [31:0] a,
                      input logic [31:0] exp_d, input logic exp_e);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(posedge clk);
        #(PERIOD/4);
        chk({tag, " data"}, bus_rdata, exp_d);
        chk({tag, " err"}, 32'(par_err), 32'(exp_e));
        chk({tag, " valid"}, 32'(bus_rvalid), 32'd1);
        @(negedge clk);
        idle_bus();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rvalid", 32'(bus_rvalid), 0);
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 viol", 32'(wr_viol), 0);
        chk("R1 err", 32'(par_err), 0);
        chk("R1 brk", 32'(brk_out), 0);
        chk("R1 flag", 32'(err_flag), 0);
        chk("R1 cfg", {prot_o, par_en_o, link_o}, 0);
        rst_n = 1;

        cfg(3'd0, 1);                                   // checking on
        // R2, R4: full words in several pages
        wr(BASE + 32'h000, 4'hF, 32'hA5A5_0F0F);
        wr(BASE + 32'h404, 4'hF, 32'h0123_4567);
        wr(BASE + 32'hBFC, 4'hF, 32'hFFFF_FFFF);
        wr(BASE + 32'hFFC, 4'hF, 32'h8000_0001);
        rd("R4", BASE + 32'h000, 32'hA5A5_0F0F, 0);
        rd("R2", BASE + 32'h404, 32'h0123_4567, 0);
        rd("R4", BASE + 32'hBFC, 32'hFFFF_FFFF, 0);
        rd("R2", BASE + 32'hFFC, 32'h8000_0001, 0);

        // R3 partial writes
        wr(BASE + 32'h000, 4'b0101, 32'h1122_3344);
        rd("R3", BASE + 32'h000, 32'hA522_0F44, 0);
        wr(BASE + 32'h000, 4'b1000, 32'h7700_0000);
        rd("R3", BASE + 32'h000, 32'h7722_0F44, 0);

        // R5 injected error on lane 2, flag R7
        cfg(3'd4, 32'h4);
        wr(BASE + 32'h010, 4'hF, 32'hDEAD_BEEF);
        cfg(3'd4, 0);
        rd("R5", BASE + 32'h010, 32'hDEAD_BEEF, 1);
        @(posedge clk); #(PERIOD/4);
        chk("R7 flag set", 32'(err_flag), 1);
        rd("R5 clean", BASE + 32'h404, 32'h0123_4567, 0);
        chk("R7 flag held", 32'(err_flag), 1);
        cfg(3'd3, 1);
        chk("R7 flag cleared", 32'(err_flag), 0);

        // R8 link
        rd("R8 unlinked", BASE + 32'h010, 32'hDEAD_BEEF, 1);
        cfg(3'd2, 1);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = BASE + 32'h010;
        @(posedge clk); #(PERIOD/4);
        chk("R8 brk", 32'(brk_out), 1);
        @(negedge clk); idle_bus();
        cfg(3'd2, 0);
        chk("R8 link kept", 32'(link_o), 1);

        // R7 set outranks clear in the same cycle
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = BASE + 32'h010;
        @(negedge clk);
        idle_bus(); cfg_we = 1; cfg_sel = 3'd3; cfg_wdata = 1;
        @(negedge clk);
        idle_bus();
        chk("R7 set wins", 32'(err_flag), 1);
        cfg(3'd3, 1);

        // R6 checking off
        cfg(3'd0, 0);
        rd("R6", BASE + 32'h010, 32'hDEAD_BEEF, 0);
        @(posedge clk); #(PERIOD/4);
        chk("R6 flag", 32'(err_flag), 0);
        cfg(3'd0, 1);
        // repair lane 2 only
        wr(BASE + 32'h010, 4'b0100, 32'h00AD_0000);
        rd("R3 repaired", BASE + 32'h010, 32'hDEAD_BEEF, 0);

        // R9 page locks, boundary between page 1 and page 2
        cfg(3'd1, 32'h4);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = BASE + 32'h800; bus_be = 4'hF; bus_wdata = 32'h5555_5555;
        @(posedge clk); #(PERIOD/4);
        chk("R9 viol", 32'(wr_viol), 1);
        @(negedge clk); idle_bus();
        @(posedge clk); #(PERIOD/4);
        chk("R9 viol one cycle", 32'(wr_viol), 0);
        wr(BASE + 32'hBFC, 4'hF, 32'h0);
        rd("R9 kept", BASE + 32'hBFC, 32'hFFFF_FFFF, 0);
        wr(BASE + 32'h7FC, 4'hF, 32'h1357_9BDF);
        rd("R9 neighbour", BASE + 32'h7FC, 32'h1357_9BDF, 0);
        cfg(3'd1, 0);
        wr(BASE + 32'hBFC, 4'h1, 32'h0000_0012);
        rd("R9 unlocked", BASE + 32'hBFC, 32'hFFFF_FF12, 0);

        // R10 outside the window
        wr(BASE + WIN, 4'hF, 32'hCAFE_CAFE);
        wr(BASE - 4, 4'hF, 32'hCAFE_CAFE);
        rd("R10 above", BASE + WIN, 0, 0);
        rd("R10 below", BASE - 4, 0, 0);
        rd("R10 no alias", BASE + 32'h000, 32'h7722_0F44, 0);

        // R2 back-to-back reads
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = BASE + 32'h404;
        @(negedge clk); bus_addr = BASE + 32'hFFC;
        @(negedge clk); bus_addr = BASE + 32'h010;
        @(negedge clk); idle_bus();
        repeat (3) @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule